// File: doc/BRIEF.md
# Update-protocol coherence controller for a small snooping cache

The block keeps the coherence state of every resident line of a small direct-mapped write-back cache that shares a snooping bus with peer caches. The coherence scheme is update based. A write to data that other caches also hold sends the single written word across the bus, so the peers patch their copies and keep them. The peers do not lose their copies. A resident line is always in one of four states: exclusive-clean, shared-clean, shared-owned (dirty, and this cache answers reads for it) and modified (dirty, and the only copy). There is no invalid state. A line that is not resident is a miss.

The processor side is a valid/ready request channel. `cpu_req_ready` is high only while the controller is idle, and a request is accepted in a cycle where both `cpu_req_valid` and `cpu_req_ready` are high. The response is a single-cycle `cpu_rsp_valid` pulse with no back-pressure, so the requester must take it in that cycle.

On the bus side the controller raises `bus_req` and holds its command, address, offset, word and line stable until `bus_gnt` arrives. The transaction takes place in the cycle where both are high. In that same cycle the environment returns `bus_shared_in` and the fill line. Snoops from other caches arrive on the `snp_*` pins one cycle at a time. The controller answers them combinationally with the shared wire and, when it owns dirty data, a flush.

Top module: `dragon_line_ctrl`

## Requirements
- R1: A read miss issues a bus read (`bus_cmd` = 1) for the requested line address. The line is installed exclusive-clean when `bus_shared_in` is low at the grant, and shared-clean when it is high.
- R2: A write miss issues a bus read with the fill merged with the written word. If `bus_shared_in` was high at that grant, an update transaction (`bus_cmd` = 2) follows and the line becomes shared-owned. Otherwise the line becomes modified with no update.
- R3: A write hit on an exclusive-clean line makes it modified with no bus transaction. A later snooped read then shows the line as dirty.
- R4: A write hit on a shared-clean or shared-owned line issues an update carrying the line address, the word offset and the word, all valid together. The line becomes shared-owned if `bus_shared_in` is high at the grant, and modified otherwise.
- R5: When a shared-clean or shared-owned line snoops an update (`snp_cmd` = 2), the broadcast word is written into the line at `snp_off`. A shared-owned line then becomes shared-clean.
- R6: When a modified or shared-owned line snoops a read (`snp_cmd` = 1), it raises `snp_shared` and `snp_flush` and presents the whole line on `snp_line`. A modified line then becomes shared-owned.
- R7: When an exclusive-clean line snoops a read, it raises `snp_shared` without a flush and becomes shared-clean.
- R8: Read hits in any state, and write hits in the exclusive-clean or modified states, use no bus transaction. Their response arrives one cycle after acceptance.
- R9: A miss whose victim is shared-owned or modified first writes the victim back (`bus_cmd` = 3) with its own address and data, and only then reads. Exclusive-clean and shared-clean victims are dropped with no bus transaction.
- R10: While `bus_req` is high without `bus_gnt`, the command stays unchanged. `cpu_req_ready` is low while any bus transaction is pending.
- R11: A snoop of a line that is not resident raises neither `snp_shared` nor `snp_flush`.
- R12: After reset no line is resident, `cpu_req_ready` is high and `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address |
| cpu_req_off | input | OFF_W | Word offset within the line |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_data | output | DATA_W | Read word, or the written word for writes |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 update, 3 write-back |
| bus_addr | output | ADDR_W | Transaction line address |
| bus_off | output | OFF_W | Word offset of an update |
| bus_word | output | DATA_W | Word of an update |
| bus_line_out | output | WORDS*DATA_W | Line data for a write-back |
| bus_fill | input | WORDS*DATA_W | Line data returned for a read at the grant |
| bus_shared_in | input | 1 | Shared wire sampled at the grant |
| snp_cmd | input | 2 | Snooped command from another cache |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_off | input | OFF_W | Snooped update offset |
| snp_word | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies the line |
| snp_line | output | WORDS*DATA_W | Flushed line data |

## Verification
A local hit must produce its response in the first cycle after the accepting edge. The bench samples at the falling edge that follows and counts the cycles it waits, so a late hit response is caught. A bus command becomes visible in the cycle after acceptance or after the previous grant. The bench checks each command at a falling edge and grants with a random delay, which also exercises the hold rule. Snoop answers are combinational: the bench samples them one nanosecond after it drives the snoop, then lets one edge pass before it uses the new state in its reference model.

// File: rtl/dragon_pkg.sv
package dragon_pkg;
  typedef enum logic [1:0] {
    ST_EXCL = 2'd0,
    ST_SCLN = 2'd1,
    ST_SOWN = 2'd2,
    ST_MOD  = 2'd3
  } line_st_e;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_RD   = 2'd1;
  localparam logic [1:0] CMD_UPD  = 2'd2;
  localparam logic [1:0] CMD_WB   = 2'd3;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_WB   = 2'd1,
    F_RD   = 2'd2,
    F_UPD  = 2'd3
  } fsm_e;
endpackage

// File: rtl/dragon_snoop_dec.sv
module dragon_snoop_dec
  import dragon_pkg::*;
(
  input  logic       hit,
  input  logic [1:0] cmd,
  input  line_st_e   st,
  output logic       shared,
  output logic       flush,
  output logic       patch,
  output line_st_e   nxt
);
  always_comb begin
    shared = hit && (cmd == CMD_RD || cmd == CMD_UPD);
    flush  = 1'b0;
    patch  = 1'b0;
    nxt    = st;
    if (hit && cmd == CMD_RD) begin
      flush = (st == ST_MOD) || (st == ST_SOWN);
      if (st == ST_EXCL) nxt = ST_SCLN;
      else if (st == ST_MOD) nxt = ST_SOWN;
    end
    if (hit && cmd == CMD_UPD && (st == ST_SCLN || st == ST_SOWN)) begin
      patch = 1'b1;
      nxt   = ST_SCLN;
    end
  end
endmodule

// File: rtl/dragon_req_plan.sv
module dragon_req_plan
  import dragon_pkg::*;
(
  input  logic     hit,
  input  logic     write,
  input  logic     present,
  input  line_st_e st,
  output logic     local_done,
  output logic     go_upd,
  output logic     go_wb,
  output line_st_e hit_nxt
);
  logic dirty;
  assign dirty      = (st == ST_SOWN) || (st == ST_MOD);
  assign local_done = hit && (!write || st == ST_EXCL || st == ST_MOD);
  assign go_upd     = hit && write && (st == ST_SCLN || st == ST_SOWN);
  assign go_wb      = !hit && present && dirty;
  assign hit_nxt    = write ? ST_MOD : st;
endmodule

// File: rtl/dragon_line_ctrl.sv
module dragon_line_ctrl
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req_valid,
  output logic                      cpu_req_ready,
  input  logic                      cpu_req_write,
  input  logic [ADDR_W-1:0]         cpu_req_addr,
  input  logic [$clog2(WORDS)-1:0]  cpu_req_off,
  input  logic [DATA_W-1:0]         cpu_req_wdata,
  output logic                      cpu_rsp_valid,
  output logic [DATA_W-1:0]         cpu_rsp_data,
  output logic                      bus_req,
  input  logic                      bus_gnt,
  output logic [1:0]                bus_cmd,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [$clog2(WORDS)-1:0]  bus_off,
  output logic [DATA_W-1:0]         bus_word,
  output logic [WORDS*DATA_W-1:0]   bus_line_out,
  input  logic [WORDS*DATA_W-1:0]   bus_fill,
  input  logic                      bus_shared_in,
  input  logic [1:0]                snp_cmd,
  input  logic [ADDR_W-1:0]         snp_addr,
  input  logic [$clog2(WORDS)-1:0]  snp_off,
  input  logic [DATA_W-1:0]         snp_word,
  output logic                      snp_shared,
  output logic                      snp_flush,
  output logic [WORDS*DATA_W-1:0]   snp_line
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = WORDS * DATA_W;

  logic [LINES-1:0]                         vld;
  logic [TAG_W-1:0]                         tag_q [LINES];
  line_st_e                                 st_q  [LINES];
  logic [LINES-1:0][WORDS-1:0][DATA_W-1:0]  dat_q;

  fsm_e              fsm;
  logic              q_write, q_from_miss;
  logic [ADDR_W-1:0] q_addr;
  logic [OFF_W-1:0]  q_off;
  logic [DATA_W-1:0] q_wdata;
  logic [IDX_W-1:0]  q_idx;
  assign q_idx = q_addr[IDX_W-1:0];

  // processor-side lookup
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic             r_hit;
  assign r_idx = cpu_req_addr[IDX_W-1:0];
  assign r_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign r_hit = vld[r_idx] && (tag_q[r_idx] == r_tag);

  logic     p_local, p_upd, p_wb;
  line_st_e p_hit_nxt;
  dragon_req_plan u_plan (
    .hit(r_hit), .write(cpu_req_write), .present(vld[r_idx]), .st(st_q[r_idx]),
    .local_done(p_local), .go_upd(p_upd), .go_wb(p_wb), .hit_nxt(p_hit_nxt)
  );

  // snoop-side lookup
  logic [IDX_W-1:0] s_idx;
  logic             s_hit, s_patch;
  line_st_e         s_nxt;
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_hit = vld[s_idx] && (tag_q[s_idx] == snp_addr[ADDR_W-1:IDX_W]);

  dragon_snoop_dec u_snp (
    .hit(s_hit), .cmd(snp_cmd), .st(st_q[s_idx]),
    .shared(snp_shared), .flush(snp_flush), .patch(s_patch), .nxt(s_nxt)
  );
  assign snp_line = dat_q[s_idx];

  // bus side
  assign cpu_req_ready = (fsm == F_IDLE);
  assign bus_req       = (fsm != F_IDLE);
  assign bus_off       = q_off;
  assign bus_word      = q_wdata;
  assign bus_line_out  = dat_q[q_idx];

  always_comb begin
    case (fsm)
      F_WB:    bus_cmd = CMD_WB;
      F_RD:    bus_cmd = CMD_RD;
      F_UPD:   bus_cmd = CMD_UPD;
      default: bus_cmd = CMD_NONE;
    endcase
    bus_addr = (fsm == F_WB) ? {tag_q[q_idx], q_idx} : q_addr;
  end

  logic [LINE_W-1:0] fill_m;
  always_comb begin
    fill_m = bus_fill;
    if (q_write) fill_m[q_off*DATA_W +: DATA_W] = q_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld           <= '0;
      dat_q         <= '0;
      fsm           <= F_IDLE;
      q_write       <= 1'b0;
      q_from_miss   <= 1'b0;
      q_addr        <= '0;
      q_off         <= '0;
      q_wdata       <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_EXCL;
      end
    end else begin
      cpu_rsp_valid <= 1'b0;
      if (s_hit) begin
        st_q[s_idx] <= s_nxt;
        if (s_patch) dat_q[s_idx][snp_off] <= snp_word;
      end
      case (fsm)
        F_IDLE: if (cpu_req_valid) begin
          q_write     <= cpu_req_write;
          q_addr      <= cpu_req_addr;
          q_off       <= cpu_req_off;
          q_wdata     <= cpu_req_wdata;
          q_from_miss <= 1'b0;
          if (p_local) begin
            cpu_rsp_valid <= 1'b1;
            if (cpu_req_write) begin
              dat_q[r_idx][cpu_req_off] <= cpu_req_wdata;
              st_q[r_idx]               <= p_hit_nxt;
              cpu_rsp_data              <= cpu_req_wdata;
            end else begin
              cpu_rsp_data <= dat_q[r_idx][cpu_req_off];
            end
          end else if (p_upd) begin
            dat_q[r_idx][cpu_req_off] <= cpu_req_wdata;
            fsm                       <= F_UPD;
          end else if (p_wb) begin
            fsm <= F_WB;
          end else begin
            fsm <= F_RD;
          end
        end
        F_WB: if (bus_gnt) begin
          vld[q_idx] <= 1'b0;
          fsm        <= F_RD;
        end
        F_RD: if (bus_gnt) begin
          vld[q_idx]   <= 1'b1;
          tag_q[q_idx] <= q_addr[ADDR_W-1:IDX_W];
          dat_q[q_idx] <= fill_m;
          if (!q_write) begin
            st_q[q_idx]   <= bus_shared_in ? ST_SCLN : ST_EXCL;
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= bus_fill[q_off*DATA_W +: DATA_W];
            fsm           <= F_IDLE;
          end else if (bus_shared_in) begin
            st_q[q_idx] <= ST_SOWN;
            q_from_miss <= 1'b1;
            fsm         <= F_UPD;
          end else begin
            st_q[q_idx]   <= ST_MOD;
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= q_wdata;
            fsm           <= F_IDLE;
          end
        end
        F_UPD: if (bus_gnt) begin
          st_q[q_idx]   <= (q_from_miss || bus_shared_in) ? ST_SOWN : ST_MOD;
          cpu_rsp_valid <= 1'b1;
          cpu_rsp_data  <= q_wdata;
          fsm           <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dragon_line_ctrl_chk.sv
module dragon_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic       cpu_req_ready,
  input logic       cpu_rsp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_shared,
  input logic       snp_flush
);
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_ready); // R10
  AST_FLUSH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_shared); // R6
  AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_cmd == 2'd1); // R6
  AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> snp_cmd != 2'd0); // R11
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !bus_req); // R8
endmodule

bind dragon_line_ctrl dragon_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .snp_cmd(snp_cmd), .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/dragon_line_ctrl_test.sv
module dragon_line_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        cpu_req_valid = 0, cpu_req_write = 0;
  logic [5:0]  cpu_req_addr = 0;
  logic [1:0]  cpu_req_off = 0;
  logic [15:0] cpu_req_wdata = 0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_data;
  logic        bus_req, bus_gnt = 0, bus_shared_in = 0;
  logic [1:0]  bus_cmd, bus_off;
  logic [5:0]  bus_addr;
  logic [15:0] bus_word;
  logic [63:0] bus_line_out, bus_fill, snp_line;
  logic [1:0]  snp_cmd = 0, snp_off = 0;
  logic [5:0]  snp_addr = 0;
  logic [15:0] snp_word = 0;
  logic        snp_shared, snp_flush;

  int checks = 0, errors = 0;
  logic [15:0] mem [256];
  bit          rv   [4];
  logic [3:0]  rtag [4];
  logic [1:0]  rst  [4];   // 0 excl, 1 shared-clean, 2 shared-owned, 3 modified
  logic [15:0] rdat [4][4];

  always #5 clk = ~clk;

  dragon_line_ctrl uut (.*);

  always_comb
    for (int w = 0; w < 4; w++) bus_fill[w*16 +: 16] = mem[{bus_addr, 2'(w)}];

  function automatic logic [63:0] line_of(int i);
    return {rdat[i][3], rdat[i][2], rdat[i][1], rdat[i][0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cpu_op(input bit wr, input logic [5:0] a, input logic [1:0] o,
                        input logic [15:0] d, input bit sh);
    int idx = int'(a[1:0]);
    logic [3:0] tg = a[5:2];
    bit hit = rv[idx] && rtag[idx] == tg;
    logic [1:0] st = rst[idx];
    bit lcl = hit && (!wr || st == 2'd0 || st == 2'd3);
    logic [1:0] ex [3];
    int ne = 0, k = 0, cyc = 0;
    bit done = 0;
    logic [15:0] got = 0;
    if (!hit) begin
      if (rv[idx] && (st == 2'd2 || st == 2'd3)) begin ex[ne] = 2'd3; ne++; end
      ex[ne] = 2'd1; ne++;
      if (wr && sh) begin ex[ne] = 2'd2; ne++; end
    end else if (wr && !lcl) begin
      ex[ne] = 2'd2; ne++;
    end
    @(negedge clk);
    chk(cpu_req_ready, "R10", 64'(cpu_req_ready), 1);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_off = o; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 0;
    while (!done && cyc < 40) begin
      if (bus_req) begin
        if (k < ne)
          chk(bus_cmd == ex[k], ex[k] == 2'd3 ? "R9" : (ex[k] == 2'd1 ? (wr ? "R2" : "R1") : (hit ? "R4" : "R2")),
              64'(bus_cmd), 64'(ex[k]));
        else
          chk(0, hit ? "R8" : "R9", 64'(bus_cmd), 0);
        chk(!cpu_req_ready, "R10", 64'(cpu_req_ready), 0);
        if (bus_cmd == 2'd3) begin
          chk(bus_addr == {rtag[idx], a[1:0]}, "R9", 64'(bus_addr), 64'({rtag[idx], a[1:0]}));
          chk(bus_line_out == line_of(idx), "R9", bus_line_out, line_of(idx));
        end else if (bus_cmd == 2'd1) begin
          chk(bus_addr == a, wr ? "R2" : "R1", 64'(bus_addr), 64'(a));
        end else if (bus_cmd == 2'd2) begin
          chk(bus_addr == a && bus_off == o && bus_word == d, "R4",
              64'({bus_addr, bus_off, bus_word}), 64'({a, o, d}));
        end
        if ($urandom_range(0, 2) == 0) begin
          bus_gnt = 0;
        end else begin
          if (bus_cmd == 2'd3)
            for (int w = 0; w < 4; w++) mem[{rtag[idx], a[1:0], 2'(w)}] = rdat[idx][w];
          bus_gnt = 1; bus_shared_in = sh; k++;
        end
      end else begin
        bus_gnt = 0;
      end
      if (cpu_rsp_valid) begin
        done = 1; got = cpu_rsp_data;
      end else begin
        cyc++;
        @(negedge clk);
      end
    end
    bus_gnt = 0;
    chk(done, "R8", 64'(done), 1);
    chk(k == ne, hit ? "R8" : "R9", 64'(k), 64'(ne));
    if (lcl) chk(cyc == 0, st == 2'd0 && wr ? "R3" : "R8", 64'(cyc), 0);
    if (!hit) begin
      rv[idx] = 1; rtag[idx] = tg;
      for (int w = 0; w < 4; w++) rdat[idx][w] = mem[{a, 2'(w)}];
      if (wr) rdat[idx][o] = d;
      rst[idx] = wr ? (sh ? 2'd2 : 2'd3) : (sh ? 2'd1 : 2'd0);
    end else if (wr) begin
      rdat[idx][o] = d;
      if (st == 2'd0 || st == 2'd3) rst[idx] = 2'd3;
      else rst[idx] = sh ? 2'd2 : 2'd3;
    end
    chk(got == rdat[idx][o], wr ? (hit ? "R4" : "R2") : (hit ? "R8" : "R1"), 64'(got), 64'(rdat[idx][o]));
  endtask

  task automatic snoop(input logic [1:0] c, input logic [5:0] a, input logic [1:0] o, input logic [15:0] w);
    int idx = int'(a[1:0]);
    bit hit = rv[idx] && rtag[idx] == a[5:2];
    logic [1:0] st = rst[idx];
    bit efl = hit && c == 2'd1 && (st == 2'd2 || st == 2'd3);
    string tg = !hit ? "R11" : (c == 2'd2 ? "R5" : (st == 2'd0 ? "R7" : (st == 2'd1 ? "R7" : "R6")));
    @(negedge clk);
    snp_cmd = c; snp_addr = a; snp_off = o; snp_word = w;
    #1;
    chk(snp_shared == hit, tg, 64'(snp_shared), 64'(hit));
    chk(snp_flush == efl, tg, 64'(snp_flush), 64'(efl));
    if (efl) chk(snp_line == line_of(idx), "R6", snp_line, line_of(idx));
    @(negedge clk);
    snp_cmd = 0;
    if (hit && c == 2'd1) begin
      if (st == 2'd0) rst[idx] = 2'd1;
      else if (st == 2'd3) rst[idx] = 2'd2;
    end
    if (hit && c == 2'd2 && (st == 2'd1 || st == 2'd2)) begin
      rdat[idx][o] = w; rst[idx] = 2'd1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
    for (int i = 0; i < 4; i++) begin rv[i] = 0; rtag[i] = 0; rst[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_req_ready == 1, "R12", 64'(cpu_req_ready), 1);
    chk(bus_req == 0, "R12", 64'(bus_req), 0);
    chk(cpu_rsp_valid == 0, "R12", 64'(cpu_rsp_valid), 0);
    snoop(2'd1, 6'h05, 0, 0);                 // R12 R11: nothing resident
    cpu_op(0, 6'h05, 1, 0, 0);                // R1 exclusive
    snoop(2'd1, 6'h05, 0, 0);                 // R7
    cpu_op(1, 6'h05, 2, 16'hAAAA, 1);         // R4 to shared-owned
    snoop(2'd1, 6'h05, 0, 0);                 // R6 flush, stays owned
    snoop(2'd2, 6'h05, 2, 16'h1234);          // R5 patch, to shared-clean
    cpu_op(0, 6'h05, 2, 0, 0);                // R5 R8 read returns patched word
    snoop(2'd1, 6'h05, 0, 0);                 // R6 no flush now
    cpu_op(1, 6'h09, 0, 16'hBEEF, 0);         // R9 silent evict, R2 modified
    cpu_op(1, 6'h09, 1, 16'h0F0F, 0);         // R8 local write hit
    snoop(2'd1, 6'h09, 0, 0);                 // R6 modified -> owned
    cpu_op(0, 6'h0D, 0, 0, 1);                // R9 write-back then read
    cpu_op(1, 6'h02, 3, 16'h5A5A, 1);         // R2 read + update
    cpu_op(1, 6'h03, 0, 16'h7777, 0);         // R2 modified
    cpu_op(0, 6'h07, 0, 0, 0);                // R9 write-back of modified
    cpu_op(1, 6'h07, 1, 16'h3C3C, 0);         // R3 exclusive write hit
    snoop(2'd1, 6'h07, 0, 0);                 // R3 dirty seen as flush
    for (int n = 0; n < 400; n++) begin
      logic [5:0] a = 6'($urandom_range(0, 15));
      logic [1:0] o = 2'($urandom_range(0, 3));
      logic [15:0] d = 16'($urandom);
      int r = $urandom_range(0, 9);
      int idx = int'(a[1:0]);
      bit hit = rv[idx] && rtag[idx] == a[5:2];
      if (r < 3) cpu_op(0, a, o, d, bit'($urandom_range(0, 1)));
      else if (r < 6) cpu_op(1, a, o, d, bit'($urandom_range(0, 1)));
      else if (r < 8) snoop(2'd1, a, o, d);
      else if (!(hit && (rst[idx] == 2'd0 || rst[idx] == 2'd3))) snoop(2'd2, a, o, d);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule